// File: doc/BRIEF.md
# Dual-Clock Table RAM with Narrow Host Port and Wide Read Port

This block is a table memory shared between a host processor and internal datapath logic that runs on its own clock. The host side sees a halfword-addressed store that it can read and write. The datapath side sees part of the same storage as a read-only array of 32-bit words. Each wide word is formed from two neighbouring halfwords.

The storage is split into lanes, one per halfword position inside a wide word. The lowest bit of the host address selects the lane. A wide read fetches the same row from every lane at once. The memory is written as plain behavioural arrays, so a synthesis tool can map each lane onto a true dual-clock RAM.

The host uses the narrow port to load coefficients or gain tables. The datapath then streams whole words through the wide port without any width conversion of its own.

Top module: `dwram_top`

## Requirements
- R1: When `n_en_i` and `n_we_i` are both high at a rising edge of `n_clk_i`, `n_wdata_i` is stored at halfword `n_addr_i`. A read cycle (`n_en_i` high, `n_we_i` low) at any of the 1024 addresses returns the last value written there.
- R2: Narrow read data is registered. It changes only at the `n_clk_i` edge that samples the read request and is valid right after that edge. Between edges, changing the address has no effect on `n_rdata_o`.
- R3: On a narrow write cycle, `n_rdata_o` presents the contents the location held before that write (read-before-write).
- R4: While `n_en_i` is low, no write takes place even if `n_we_i` is high, and `n_rdata_o` keeps its value.
- R5: A wide read with `w_en_i` high at a rising edge of `w_clk_i` returns word k = `w_addr_i` as {halfword 2k+1 in bits 31:16, halfword 2k in bits 15:0}, registered with one `w_clk_i` cycle of latency.
- R6: Halfwords 256 to 1023 read and write normally on the narrow port, but a write to them never changes any wide word 0 to 127.
- R7: While `w_en_i` is low, `w_rdata_o` keeps its value whatever `w_addr_i` does.
- R8: Each port has its own synchronous active-low reset that clears only that port's read output to zero. It does not touch the other port or the stored contents.
- R9: The two ports run on independent, unrelated clocks. A wide read and a narrow write to the same halfword in overlapping cycles give an undefined wide result and are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| n_clk_i | input | 1 | Host port clock |
| n_rst_ni | input | 1 | Host port synchronous reset, active low |
| n_en_i | input | 1 | Host port enable |
| n_we_i | input | 1 | Host write request, acted on only with enable |
| n_addr_i | input | 10 | Host halfword address |
| n_wdata_i | input | 16 | Host write data |
| n_rdata_o | output | 16 | Host registered read data |
| w_clk_i | input | 1 | Wide port clock |
| w_rst_ni | input | 1 | Wide port synchronous reset, active low |
| w_en_i | input | 1 | Wide port read enable |
| w_addr_i | input | 7 | Wide word address |
| w_rdata_o | output | 32 | Wide registered read data |

## Verification
Two cases are the hardest to reach from the ports. The first is read-before-write, which requires a write to a location whose earlier contents are known and different from the new data. The second is proving that writes to the upper three quarters of the halfword space stay out of the wide view. The stimulus first fills all 1024 halfwords with an arithmetic pattern. It then overwrites the lower 256 with a second pattern, checking the old value on each write, and overwrites the upper 768 with a third. Every wide word is swept after each phase and compared with the bench's own model. Wide reads are never issued while a narrow write is in progress, which keeps the undefined collision case out of the run.

// File: rtl/dwram_pkg.sv
package dwram_pkg;
    // Default geometry shared by the RAM and its checker.
    localparam int DEF_DATA_W    = 16;  // halfword width
    localparam int DEF_NARROW_AW = 10;  // host halfword address width
    localparam int DEF_WIDE_AW   = 7;   // wide word address width
    localparam int DEF_LANES     = 2;   // halfwords per wide word, power of two >= 2
endpackage

// File: rtl/dwram_bank.sv
// One lane of storage: written and read by the host clock, read by the wide clock.
module dwram_bank #(
    parameter int DATA_W = 16,
    parameter int ROW_AW = 9,
    localparam int DEPTH = 1 << ROW_AW
) (
    input  logic              n_clk_i,
    input  logic              n_rst_ni,
    input  logic              n_rd_en_i,
    input  logic              n_wr_en_i,
    input  logic [ROW_AW-1:0] n_row_i,
    input  logic [DATA_W-1:0] n_wdata_i,
    output logic [DATA_W-1:0] n_rdata_o,
    input  logic              w_clk_i,
    input  logic              w_rst_ni,
    input  logic              w_en_i,
    input  logic [ROW_AW-1:0] w_row_i,
    output logic [DATA_W-1:0] w_rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] n_rd_d, n_rd_q;
    logic [DATA_W-1:0] w_rd_d, w_rd_q;

    // Storage update on the host clock.
    always_ff @(posedge n_clk_i) begin
        if (n_wr_en_i) begin
            mem[n_row_i] <= n_wdata_i;
        end
    end

    // Next values of both output registers.
    always_comb begin
        n_rd_d = n_rd_q;
        if (n_rd_en_i) begin
            n_rd_d = mem[n_row_i];
        end
        w_rd_d = w_rd_q;
        if (w_en_i) begin
            w_rd_d = mem[w_row_i];
        end
    end

    // Host side output register: samples old contents on a write cycle.
    always_ff @(posedge n_clk_i) begin
        if (!n_rst_ni) begin
            n_rd_q <= '0;
        end else begin
            n_rd_q <= n_rd_d;
        end
    end

    // Wide side output register on its own clock.
    always_ff @(posedge w_clk_i) begin
        if (!w_rst_ni) begin
            w_rd_q <= '0;
        end else begin
            w_rd_q <= w_rd_d;
        end
    end

    assign n_rdata_o = n_rd_q;
    assign w_rdata_o = w_rd_q;
endmodule

// File: rtl/dwram_nport.sv
// Host side lane selector: remembers which lane the last read addressed.
module dwram_nport #(
    parameter int DATA_W  = 16,
    parameter int LANES   = 2,
    localparam int LANE_AW = $clog2(LANES)
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          en_i,
    input  logic [LANE_AW-1:0]            lane_i,
    input  logic [LANES-1:0][DATA_W-1:0]  lane_data_i,
    output logic [DATA_W-1:0]             rdata_o
);
    typedef struct packed {
        logic [LANE_AW-1:0] lane;
    } nsel_t;

    nsel_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.lane = lane_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = lane_data_i[st_q.lane];
endmodule

// File: rtl/dwram_top.sv
// Asymmetric dual-clock table RAM: narrow read/write host port, wide read-only port.
module dwram_top #(
    parameter int DATA_W    = dwram_pkg::DEF_DATA_W,
    parameter int NARROW_AW = dwram_pkg::DEF_NARROW_AW,
    parameter int WIDE_AW   = dwram_pkg::DEF_WIDE_AW,
    parameter int LANES     = dwram_pkg::DEF_LANES,
    localparam int LANE_AW  = $clog2(LANES),
    localparam int ROW_AW   = NARROW_AW - LANE_AW,
    localparam int WIDE_W   = DATA_W * LANES
) (
    input  logic                 n_clk_i,
    input  logic                 n_rst_ni,
    input  logic                 n_en_i,
    input  logic                 n_we_i,
    input  logic [NARROW_AW-1:0] n_addr_i,
    input  logic [DATA_W-1:0]    n_wdata_i,
    output logic [DATA_W-1:0]    n_rdata_o,
    input  logic                 w_clk_i,
    input  logic                 w_rst_ni,
    input  logic                 w_en_i,
    input  logic [WIDE_AW-1:0]   w_addr_i,
    output logic [WIDE_W-1:0]    w_rdata_o
);
    logic [LANE_AW-1:0]           n_lane;
    logic [ROW_AW-1:0]            n_row;
    logic [ROW_AW-1:0]            w_row;
    logic [LANES-1:0][DATA_W-1:0] n_lane_data;
    logic [LANES-1:0][DATA_W-1:0] w_lane_data;

    // Host address: low bits pick the lane, the rest pick the row.
    assign n_lane = n_addr_i[LANE_AW-1:0];
    assign n_row  = n_addr_i[NARROW_AW-1:LANE_AW];

    // Wide address maps onto the lowest rows only.
    generate
        if (ROW_AW > WIDE_AW) begin : g_row_ext
            assign w_row = {{(ROW_AW-WIDE_AW){1'b0}}, w_addr_i};
        end else begin : g_row_eq
            assign w_row = w_addr_i[ROW_AW-1:0];
        end
    endgenerate

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic lane_wr;
            assign lane_wr = n_en_i && n_we_i && (n_lane == LANE_AW'(g));

            dwram_bank #(
                .DATA_W (DATA_W),
                .ROW_AW (ROW_AW)
            ) u_bank (
                .n_clk_i   (n_clk_i),
                .n_rst_ni  (n_rst_ni),
                .n_rd_en_i (n_en_i),
                .n_wr_en_i (lane_wr),
                .n_row_i   (n_row),
                .n_wdata_i (n_wdata_i),
                .n_rdata_o (n_lane_data[g]),
                .w_clk_i   (w_clk_i),
                .w_rst_ni  (w_rst_ni),
                .w_en_i    (w_en_i),
                .w_row_i   (w_row),
                .w_rdata_o (w_lane_data[g])
            );
        end
    endgenerate

    dwram_nport #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_nport (
        .clk_i       (n_clk_i),
        .rst_ni      (n_rst_ni),
        .en_i        (n_en_i),
        .lane_i      (n_lane),
        .lane_data_i (n_lane_data),
        .rdata_o     (n_rdata_o)
    );

    // Higher lane lands in the higher bits of the wide word.
    assign w_rdata_o = w_lane_data;
endmodule

// File: rtl/dwram_chk.sv
// Port-level properties of the table RAM, attached by bind.
module dwram_chk #(
    parameter int DATA_W    = 16,
    parameter int NARROW_AW = 10,
    parameter int WIDE_AW   = 7,
    parameter int WIDE_W    = 32
) (
    input logic                 n_clk_i,
    input logic                 n_rst_ni,
    input logic                 n_en_i,
    input logic                 n_we_i,
    input logic [NARROW_AW-1:0] n_addr_i,
    input logic [DATA_W-1:0]    n_wdata_i,
    input logic [DATA_W-1:0]    n_rdata_o,
    input logic                 w_clk_i,
    input logic                 w_rst_ni,
    input logic                 w_en_i,
    input logic [WIDE_AW-1:0]   w_addr_i,
    input logic [WIDE_W-1:0]    w_rdata_o
);
    // R1: read right after a write to the same halfword returns the written data
    p_raw_r1: assert property (@(posedge n_clk_i) disable iff (!n_rst_ni)
        (n_en_i && !n_we_i && $past(n_en_i && n_we_i) && n_addr_i == $past(n_addr_i))
        |=> n_rdata_o == $past(n_wdata_i, 2));

    // R3: second of two writes to one halfword shows the first write's data
    p_rbw_r3: assert property (@(posedge n_clk_i) disable iff (!n_rst_ni)
        (n_en_i && n_we_i && $past(n_en_i && n_we_i) && n_addr_i == $past(n_addr_i))
        |=> n_rdata_o == $past(n_wdata_i, 2));

    // R4: host output holds while the port is disabled
    p_nhold_r4: assert property (@(posedge n_clk_i) disable iff (!n_rst_ni)
        !n_en_i |=> $stable(n_rdata_o));

    // R7: wide output holds while the wide port is disabled
    p_whold_r7: assert property (@(posedge w_clk_i) disable iff (!w_rst_ni)
        !w_en_i |=> $stable(w_rdata_o));

    // R7: a disabled wide port ignores its address bus
    p_waddr_r7: assert property (@(posedge w_clk_i) disable iff (!w_rst_ni)
        (!w_en_i && !$stable(w_addr_i)) |=> $stable(w_rdata_o));
endmodule

bind dwram_top dwram_chk #(
    .DATA_W    (DATA_W),
    .NARROW_AW (NARROW_AW),
    .WIDE_AW   (WIDE_AW),
    .WIDE_W    (WIDE_W)
) u_chk (
    .n_clk_i   (n_clk_i),
    .n_rst_ni  (n_rst_ni),
    .n_en_i    (n_en_i),
    .n_we_i    (n_we_i),
    .n_addr_i  (n_addr_i),
    .n_wdata_i (n_wdata_i),
    .n_rdata_o (n_rdata_o),
    .w_clk_i   (w_clk_i),
    .w_rst_ni  (w_rst_ni),
    .w_en_i    (w_en_i),
    .w_addr_i  (w_addr_i),
    .w_rdata_o (w_rdata_o)
);

// File: tb/dwram_top_tb.sv
module dwram_top_tb;
    logic        n_clk = 1'b0;
    logic        w_clk = 1'b0;
    logic        n_rst_n = 1'b0;
    logic        w_rst_n = 1'b0;
    logic        n_en = 1'b0;
    logic        n_we = 1'b0;
    logic [9:0]  n_addr = '0;
    logic [15:0] n_wdata = '0;
    logic [15:0] n_rdata;
    logic        w_en = 1'b0;
    logic [6:0]  w_addr = '0;
    logic [31:0] w_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] model [1024];

    always #4 n_clk = ~n_clk;   // 125 MHz host clock
    always #7 w_clk = ~w_clk;   // unrelated wide clock

    dwram_top u_dut (
        .n_clk_i   (n_clk),
        .n_rst_ni  (n_rst_n),
        .n_en_i    (n_en),
        .n_we_i    (n_we),
        .n_addr_i  (n_addr),
        .n_wdata_i (n_wdata),
        .n_rdata_o (n_rdata),
        .w_clk_i   (w_clk),
        .w_rst_ni  (w_rst_n),
        .w_en_i    (w_en),
        .w_addr_i  (w_addr),
        .w_rdata_o (w_rdata)
    );

    function automatic logic [15:0] pat_a(input int a);
        return 16'((a * 40503) ^ 23130);
    endfunction
    function automatic logic [15:0] pat_b(input int a);
        return 16'(~a ^ (a << 7));
    endfunction
    function automatic logic [15:0] pat_c(input int a);
        return 16'(16'hC000 | a);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic n_op(input bit en, input bit we, input int a, input logic [15:0] d);
        n_en = en; n_we = we; n_addr = 10'(a); n_wdata = d;
        @(posedge n_clk); #2;
    endtask

    task automatic w_op(input bit en, input int a);
        w_en = en; w_addr = 7'(a);
        @(posedge w_clk); #2;
    endtask

    function automatic logic [31:0] wexp(input int k);
        return {model[2*k+1], model[2*k]};
    endfunction

    task automatic wide_sweep(input string req);
        for (int k = 0; k < 128; k++) begin
            w_op(1'b1, k);
            chk(w_rdata == wexp(k), req, w_rdata, wexp(k));
        end
        w_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: both outputs cleared by reset
        repeat (4) @(posedge n_clk);
        n_rst_n = 1'b1;
        @(posedge w_clk); w_rst_n = 1'b1;
        #2;
        chk(n_rdata == 16'h0, "R8 host reset", 32'(n_rdata), 32'h0);
        chk(w_rdata == 32'h0, "R8 wide reset", w_rdata, 32'h0);
        @(posedge n_clk); #2;

        // R1: fill every halfword, then read all back
        for (int a = 0; a < 1024; a++) begin
            n_op(1'b1, 1'b1, a, pat_a(a));
            model[a] = pat_a(a);
        end
        for (int a = 0; a < 1024; a++) begin
            n_op(1'b1, 1'b0, a, 16'h0);
            chk(n_rdata == model[a], "R1 readback", 32'(n_rdata), 32'(model[a]));
        end

        // R2: output changes only at the sampling edge
        n_op(1'b1, 1'b0, 0, 16'h0);
        for (int a = 1; a < 64; a++) begin
            n_addr = 10'(a);
            #1;
            chk(n_rdata == model[a-1], "R2 before edge", 32'(n_rdata), 32'(model[a-1]));
            @(posedge n_clk); #2;
            chk(n_rdata == model[a], "R2 after edge", 32'(n_rdata), 32'(model[a]));
        end
        n_en = 1'b0;

        // R5: wide view of the first pattern
        wide_sweep("R5 wide word");

        // R3: overwrite lower quarter, observe old data, then read new
        for (int a = 0; a < 256; a++) begin
            n_op(1'b1, 1'b1, a, pat_b(a));
            chk(n_rdata == model[a], "R3 read-before-write", 32'(n_rdata), 32'(model[a]));
            model[a] = pat_b(a);
            n_op(1'b1, 1'b0, a, 16'h0);
            chk(n_rdata == model[a], "R1 read after write", 32'(n_rdata), 32'(model[a]));
        end
        n_en = 1'b0;
        wide_sweep("R5 wide word after update");

        // R6: upper halfwords behave normally but stay out of the wide view
        for (int a = 256; a < 1024; a++) begin
            n_op(1'b1, 1'b1, a, pat_c(a));
            model[a] = pat_c(a);
        end
        for (int a = 256; a < 1024; a += 37) begin
            n_op(1'b1, 1'b0, a, 16'h0);
            chk(n_rdata == model[a], "R6 upper readback", 32'(n_rdata), 32'(model[a]));
        end
        n_en = 1'b0;
        wide_sweep("R6 wide unaffected by upper writes");

        // R4: disabled host port neither writes nor updates its output
        n_op(1'b1, 1'b0, 7, 16'h0);
        n_op(1'b0, 1'b1, 7, 16'hDEAD);
        chk(n_rdata == model[7], "R4 hold on write attempt", 32'(n_rdata), 32'(model[7]));
        n_op(1'b0, 1'b0, 9, 16'h0);
        chk(n_rdata == model[7], "R4 hold on address change", 32'(n_rdata), 32'(model[7]));
        n_op(1'b1, 1'b0, 7, 16'h0);
        chk(n_rdata == model[7], "R4 no write while disabled", 32'(n_rdata), 32'(model[7]));
        n_en = 1'b0;

        // R7: disabled wide port holds
        w_op(1'b1, 3);
        chk(w_rdata == wexp(3), "R7 setup", w_rdata, wexp(3));
        for (int k = 100; k < 104; k++) begin
            w_op(1'b0, k);
            chk(w_rdata == wexp(3), "R7 hold", w_rdata, wexp(3));
        end

        // R8: resets act per port only
        n_op(1'b1, 1'b0, 5, 16'h0);
        n_en = 1'b0;
        n_rst_n = 1'b0;
        @(posedge n_clk); #2;
        chk(n_rdata == 16'h0, "R8 host reset clears", 32'(n_rdata), 32'h0);
        chk(w_rdata == wexp(3), "R8 wide unaffected", w_rdata, wexp(3));
        n_rst_n = 1'b1;
        n_op(1'b1, 1'b0, 5, 16'h0);
        n_en = 1'b0;
        chk(n_rdata == model[5], "R8 contents kept", 32'(n_rdata), 32'(model[5]));
        w_rst_n = 1'b0;
        @(posedge w_clk); #2;
        chk(w_rdata == 32'h0, "R8 wide reset clears", w_rdata, 32'h0);
        chk(n_rdata == model[5], "R8 host unaffected", 32'(n_rdata), 32'(model[5]));
        w_rst_n = 1'b1;

        // R9: ports on unrelated clocks still return correct data afterwards
        w_op(1'b1, 64);
        chk(w_rdata == wexp(64), "R9 wide after host activity", w_rdata, wexp(64));
        w_en = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule